// File: doc/BRIEF.md
# Recency-Indexed Value Queue

This block keeps a short history of the most recent 64-bit results produced by an execution core. Every write inserts one value as the newest entry. Once the history holds its full sixteen entries, each further write silently discards the oldest one. Consumers never name a register number. They name an age, where age 0 is the newest value, age 1 the one before it, and so on. Two copies sit side by side in a core, one holding heap references and one holding primitive results.

Several read ports look up ages in parallel within the same cycle. Each port returns the value and a flag saying whether that age currently holds data. A flush input, driven by a bit of the instruction header, empties the history. A validity vector reports, for each age, whether it is occupied. Internally the history is a circular buffer with a head pointer, so a write touches one slot and the pointer rather than shifting every entry.

Top module: `recency_queue`

## Requirements
- R1: After reset every age reports invalid, every read port returns zero with its valid flag low, and `entry_valid_o` is all zeros.
- R2: A value written in one cycle is returned at age 0 from the next cycle on. Each value that was already held moves one age older.
- R3: Reads in a cycle that also writes return the contents from before that write. The value being written is not visible at any age until the following cycle.
- R4: The occupancy saturates at DEPTH (16). A write to a full history drops the oldest value, so age DEPTH-1 then holds what was previously at age DEPTH-2.
- R5: A read of an age at or beyond the current occupancy returns all-zero data with its valid flag low.
- R6: Asserting `clr_i` without `wr_en_i` leaves the history empty from the next cycle on.
- R7: Asserting `clr_i` together with `wr_en_i` empties the history first and then inserts the written value, leaving exactly one valid entry, at age 0.
- R8: All NUM_RD read ports are independent. In the same cycle, each port returns the entry for its own age index. Port p uses bits [p*4 +: 4] of `rd_idx_i` and bits [p*64 +: 64] of `rd_data_o`.
- R9: Bit k of `entry_valid_o` is 1 exactly when age k is occupied, so the vector is a run of ones starting at bit 0 (the newest).
- R10: In a cycle with neither write nor clear, the contents and the occupancy do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Flush the history (header bit) |
| wr_en_i | input | 1 | Insert `wr_data_i` as the newest value |
| wr_data_i | input | 64 | Value to insert |
| rd_idx_i | input | 16 | Four packed 4-bit age indices, port 0 in the low bits |
| rd_data_o | output | 256 | Four packed 64-bit read results, port 0 in the low bits |
| rd_valid_o | output | 4 | Per-port valid flag |
| entry_valid_o | output | 16 | Per-age occupancy, bit 0 is the newest |

## Verification
The bench drives a short run of distinct writes and reads ages on all four ports at once. This shows whether each value lands at age 0 and moves older by one per write, and whether the ports are truly separate. Reading in the same cycle as a write tells pre-write behaviour apart from write-through. A run of twenty writes past capacity separates a dropped oldest value from a wrapped or stuck pointer. The bench also covers a flush alone, a flush combined with a write, and reads beyond the occupancy. These cases tell the flush ordering apart and show whether stale slots are returned as zero rather than as old data.

// File: rtl/rq_pkg.sv
package rq_pkg;

   // Decoded per-cycle operation; the encoding is {clear, write}.
   typedef enum logic [1:0] {
      RQ_IDLE       = 2'b00,
      RQ_PUSH       = 2'b01,
      RQ_FLUSH      = 2'b10,
      RQ_FLUSH_PUSH = 2'b11
   } rq_op_e;

   function automatic bit rq_is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/rq_store.sv
module rq_store
   import rq_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned IDX_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  rq_op_e                         op_i,
   input  logic [DATA_W-1:0]              wr_data_i,
   output logic [DEPTH-1:0][DATA_W-1:0]   mem_o,
   output logic [IDX_W-1:0]               head_o,
   output logic [CNT_W-1:0]               count_o
);

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic [DEPTH-1:0][DATA_W-1:0] mem_q;
   logic [IDX_W-1:0]             head_q, head_d;
   logic [CNT_W-1:0]             count_q, count_d;
   logic                         do_wr;

   assign do_wr = (op_i == RQ_PUSH) || (op_i == RQ_FLUSH_PUSH);

   always_comb begin
      head_d  = head_q;
      count_d = count_q;
      unique case (op_i)
         RQ_IDLE: ;
         RQ_PUSH: begin
            head_d = head_q + 1'b1;
            if (count_q != FULL_CNT) count_d = count_q + 1'b1;
         end
         RQ_FLUSH:      count_d = '0;
         RQ_FLUSH_PUSH: begin
            head_d  = head_q + 1'b1;
            count_d = CNT_W'(1);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q  <= '0;
         count_q <= '0;
      end else begin
         head_q  <= head_d;
         count_q <= count_d;
      end
   end

   // Data slots carry no reset; stale slots are masked by occupancy.
   genvar s;
   generate
      for (s = 0; s < DEPTH; s++) begin : g_slot
         always_ff @(posedge clk) begin
            if (do_wr && (head_q == IDX_W'(s))) mem_q[s] <= wr_data_i;
         end
      end
   endgenerate

   assign mem_o   = mem_q;
   assign head_o  = head_q;
   assign count_o = count_q;

   // R4
   count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q <= FULL_CNT));

   // R4
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == RQ_PUSH && count_q == FULL_CNT) |=> (count_q == FULL_CNT));

   // R2
   slot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_wr |=> (mem_q[$past(head_q)] == $past(wr_data_i)));

   // R6
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == RQ_FLUSH) |=> (count_q == '0));

   // R7
   flush_push_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == RQ_FLUSH_PUSH) |=> (count_q == CNT_W'(1)));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == RQ_IDLE) |=> ($stable(count_q) && $stable(head_q)));

endmodule

// File: rtl/rq_rdport.sv
module rq_rdport #(
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned DEPTH      = 16,
   parameter bit          ZERO_STALE = 1'b1,
   localparam int unsigned IDX_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic [DEPTH-1:0][DATA_W-1:0] mem_i,
   input  logic [IDX_W-1:0]             head_i,
   input  logic [CNT_W-1:0]             count_i,
   input  logic [IDX_W-1:0]             age_i,
   output logic [DATA_W-1:0]            data_o,
   output logic                         valid_o
);

   logic [IDX_W-1:0]  slot;
   logic [DATA_W-1:0] raw;

   // Newest entry sits one slot behind the head; older ones further back.
   assign slot    = head_i - IDX_W'(1) - age_i;
   assign raw     = mem_i[slot];
   assign valid_o = (CNT_W'(age_i) < count_i);

   generate
      if (ZERO_STALE) begin : g_mask
         assign data_o = valid_o ? raw : '0;
      end else begin : g_raw
         assign data_o = raw;
      end
   endgenerate

endmodule

// File: rtl/recency_queue.sv
module recency_queue
   import rq_pkg::*;
#(
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned DEPTH      = 16,
   parameter int unsigned NUM_RD     = 4,
   parameter bit          ZERO_STALE = 1'b1,
   localparam int unsigned IDX_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr_i,
   input  logic                     wr_en_i,
   input  logic [DATA_W-1:0]        wr_data_i,
   input  logic [NUM_RD*IDX_W-1:0]  rd_idx_i,
   output logic [NUM_RD*DATA_W-1:0] rd_data_o,
   output logic [NUM_RD-1:0]        rd_valid_o,
   output logic [DEPTH-1:0]         entry_valid_o
);

   generate
      if (DEPTH < 2 || !rq_is_pow2(DEPTH)) begin : g_bad_depth
         $error("recency_queue: DEPTH must be a power of two, at least 2");
      end
      if (NUM_RD < 1) begin : g_bad_ports
         $error("recency_queue: NUM_RD must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("recency_queue: DATA_W must be at least 1");
      end
   endgenerate

   rq_op_e                        op;
   logic [DEPTH-1:0][DATA_W-1:0]  mem;
   logic [IDX_W-1:0]              head;
   logic [CNT_W-1:0]              count;

   assign op = rq_op_e'({clr_i, wr_en_i});

   rq_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) store_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_i      (op),
      .wr_data_i (wr_data_i),
      .mem_o     (mem),
      .head_o    (head),
      .count_o   (count)
   );

   genvar p;
   generate
      for (p = 0; p < NUM_RD; p++) begin : g_port
         rq_rdport #(
            .DATA_W     (DATA_W),
            .DEPTH      (DEPTH),
            .ZERO_STALE (ZERO_STALE)
         ) port_i (
            .mem_i   (mem),
            .head_i  (head),
            .count_i (count),
            .age_i   (rd_idx_i[p*IDX_W +: IDX_W]),
            .data_o  (rd_data_o[p*DATA_W +: DATA_W]),
            .valid_o (rd_valid_o[p])
         );
      end
   endgenerate

   genvar k;
   generate
      for (k = 0; k < DEPTH; k++) begin : g_age_valid
         assign entry_valid_o[k] = (CNT_W'(k) < count);
      end
   endgenerate

   // R9
   thermo_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(entry_valid_o) == int'(count)));

   // R7
   flush_push_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && wr_en_i) |=> (entry_valid_o == DEPTH'(1)));

   // R2
   push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !clr_i && !entry_valid_o[DEPTH-1])
         |=> ($countones(entry_valid_o) == $countones($past(entry_valid_o)) + 1));

   // R5
   stale_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_valid_o[0] && ZERO_STALE) |-> (rd_data_o[DATA_W-1:0] == '0));

endmodule

// File: tb/recency_queue_tb_top.sv
`timescale 1ns/1ps
module recency_queue_tb_top;

   localparam int DW = 64;
   localparam int DEPTH = 16;
   localparam int NRD = 4;
   localparam int IW = 4;
   localparam time TCK = 20ns;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              clr_i = 1'b0;
   logic              wr_en_i = 1'b0;
   logic [DW-1:0]     wr_data_i = '0;
   logic [NRD*IW-1:0] rd_idx_i = '0;
   logic [NRD*DW-1:0] rd_data_o;
   logic [NRD-1:0]    rd_valid_o;
   logic [DEPTH-1:0]  entry_valid_o;

   always #(TCK/2) clk = ~clk;

   recency_queue dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .clr_i         (clr_i),
      .wr_en_i       (wr_en_i),
      .wr_data_i     (wr_data_i),
      .rd_idx_i      (rd_idx_i),
      .rd_data_o     (rd_data_o),
      .rd_valid_o    (rd_valid_o),
      .entry_valid_o (entry_valid_o)
   );

   typedef struct {
      string            tag;
      int               kind;   // 0: read port, 1: validity vector
      int               port;
      logic [DW-1:0]    dat;
      logic             vld;
      logic [DEPTH-1:0] ev;
   } exp_t;

   exp_t          exp_q[$];
   logic [DW-1:0] model_q[$];   // index 0 is the newest value
   int            n_checks = 0;
   int            n_fails = 0;
   bit            finished = 0;
   event          chk_ev;

   // Monitor: compares design outputs against the queued expectations.
   initial begin
      forever begin
         @(chk_ev);
         #1;
         while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (e.kind == 0) begin
               if (rd_data_o[e.port*DW +: DW] !== e.dat || rd_valid_o[e.port] !== e.vld) begin
                  n_fails++;
                  $display("FAIL %s port%0d actual data=%h valid=%b expected data=%h valid=%b",
                           e.tag, e.port, rd_data_o[e.port*DW +: DW], rd_valid_o[e.port],
                           e.dat, e.vld);
               end
            end else begin
               if (entry_valid_o !== e.ev) begin
                  n_fails++;
                  $display("FAIL %s entry_valid actual=%b expected=%b", e.tag, entry_valid_o, e.ev);
               end
            end
         end
      end
   end

   // Driver: applies one cycle of stimulus, queues the expected pre-edge view.
   task automatic step(input logic w, input logic c, input logic [DW-1:0] d,
                       input int a0, input int a1, input int a2, input int a3,
                       input string tag);
      int ages[NRD];
      logic [DEPTH-1:0] thermo;
      ages[0] = a0; ages[1] = a1; ages[2] = a2; ages[3] = a3;
      @(negedge clk);
      wr_en_i   = w;
      clr_i     = c;
      wr_data_i = d;
      for (int p = 0; p < NRD; p++) rd_idx_i[p*IW +: IW] = IW'(ages[p]);
      for (int p = 0; p < NRD; p++) begin
         exp_t e;
         e.tag  = tag;
         e.kind = 0;
         e.port = p;
         e.vld  = (ages[p] < model_q.size());
         e.dat  = e.vld ? model_q[ages[p]] : '0;
         e.ev   = '0;
         exp_q.push_back(e);
      end
      thermo = '0;
      for (int k = 0; k < DEPTH; k++) thermo[k] = (k < model_q.size());
      begin
         exp_t e;
         e.tag = tag; e.kind = 1; e.port = 0; e.dat = '0; e.vld = 1'b0; e.ev = thermo;
         exp_q.push_back(e);
      end
      -> chk_ev;
      // Model update for the coming edge: clear first, then insert.
      if (c) model_q.delete();
      if (w) begin
         model_q.push_front(d);
         if (model_q.size() > DEPTH) void'(model_q.pop_back());
      end
   endtask

   function automatic logic [DW-1:0] val(input int n);
      return {32'hC0DE_0000 + 32'(n), 32'(n) * 32'h9E37_79B9};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state, R9 empty vector
      step(0, 0, '0, 0, 1, 7, 15, "R1 reset empty");
      // R3: write now, same-cycle read still sees empty
      step(1, 0, val(1), 0, 1, 2, 3, "R3 pre-write view");
      // R2 newest at age 0
      step(1, 0, val(2), 0, 1, 2, 3, "R2 first value at age0");
      step(1, 0, val(3), 0, 1, 2, 3, "R2 ages shift");
      step(1, 0, val(4), 2, 0, 1, 3, "R8 ports in mixed order");
      step(0, 0, '0, 3, 2, 1, 0, "R8 reverse order");
      // R10 idle holds
      step(0, 0, '0, 0, 1, 2, 3, "R10 idle hold");
      step(0, 0, '0, 0, 0, 3, 3, "R8 duplicate ages");
      // R5 beyond occupancy
      step(0, 0, '0, 4, 5, 15, 0, "R5 beyond count");
      // R6 flush alone
      step(0, 1, '0, 0, 1, 2, 3, "R6 flush issued");
      step(0, 0, '0, 0, 1, 2, 3, "R6 empty after flush");
      // R4 overfill with twenty writes
      for (int k = 0; k < 20; k++) step(1, 0, val(100 + k), 0, 1, 14, 15, "R4 filling");
      step(0, 0, '0, 0, 1, 14, 15, "R4 oldest dropped");
      step(0, 0, '0, 15, 8, 7, 0, "R9 full vector");
      // R4: write into full history, same cycle reads pre-write
      step(1, 0, val(200), 15, 14, 0, 1, "R3 write when full");
      step(0, 0, '0, 15, 14, 0, 1, "R4 shift when full");
      // R7 flush with write
      step(1, 1, val(300), 0, 1, 15, 2, "R7 flush+write issued");
      step(0, 0, '0, 0, 1, 15, 2, "R7 single entry");
      step(1, 0, val(301), 0, 1, 2, 3, "R2 after flush+write");
      step(1, 0, val(302), 0, 1, 2, 3, "R5 partial count");
      step(0, 0, '0, 3, 7, 2, 0, "R5 partial beyond");
      step(0, 0, '0, 0, 1, 2, 3, "R10 final hold");
      @(negedge clk);
      #2;
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end

   initial begin
      #(TCK * 100000);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   end

endmodule